// File: doc/BRIEF.md
# Heartbeat Consumer Supervisor

This block supervises the periodic status frames that other nodes on a CAN network broadcast to show they are alive. A small table of consumer slots, each loaded as one 32-bit word, names the producer node to watch and the longest gap in milliseconds that may pass between two of its frames. A frame decoder upstream presents each received heartbeat as a one-cycle strobe carrying the sender's node ID and its reported state byte. A free-running millisecond tick drives the elapsed-time counting.

A slot is armed by the first heartbeat from its node. A producer that has never been heard from is therefore never reported, however long it stays silent. Once armed, a slot counts ticks and reloads on every matching frame. If the configured gap elapses, the slot raises a one-cycle lapse event and stays in a lapsed state until that node is heard again. A summary event combines all slots so that a higher layer can raise an emergency or leave the operational state.

Top module: `hbmon_top`

## Requirements
- R1: A slot word holds the producer node ID in bits 22:16 and the allowed gap in milliseconds in bits 15:0. Bits 31:23 are ignored. The word is written to slot `cfgAddr` when `cfgWe` is high. For example, 0x000107D0 watches node 1 with a gap of 2000 ticks.
- R2: A slot whose node ID field is 0 or whose gap field is 0 is disabled. It never becomes active and never reports a lapse. A word of all zeros is one such case.
- R3: Until the first matching heartbeat after its last write or after reset, a slot stays inactive (`monitorActive` 0) and never reports a lapse, whatever the number of ticks.
- R4: A heartbeat whose node ID equals an enabled slot's node ID sets that slot's `monitorActive` from the next cycle and restarts its count. Heartbeats from any other node do not affect the slot. All node IDs 1 to 127 are handled alike.
- R5: For an active slot with gap T, `timeoutPulse[i]` is high for exactly one cycle. That cycle directly follows the clock edge that samples the T-th `msTick` after the last matching heartbeat. No pulse occurs earlier.
- R6: After a lapse, `lapsed[i]` stays 1 and no further pulse is given until a matching heartbeat clears `lapsed[i]` and restarts the count.
- R7: If a matching heartbeat and a tick arrive in the same cycle, the heartbeat wins. The count restarts and that tick is not counted.
- R8: Writing a slot returns it to the inactive state, clearing `monitorActive` and `lapsed`. A write takes priority over a matching heartbeat in the same cycle.
- R9: `anyTimeout` is high in exactly the cycles in which at least one `timeoutPulse` bit is high.
- R10: `entryState[8*i+7:8*i]` holds the state byte of the last matching heartbeat accepted by slot i. It is 0 after reset and is unchanged by writes.
- R11: After reset, every slot is disabled and inactive, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Slot word write strobe |
| cfgAddr | input | 2 | Slot index for the write |
| cfgWdata | input | 32 | Slot word (node ID 22:16, gap 15:0) |
| hbValid | input | 1 | Received heartbeat strobe |
| hbNodeId | input | 7 | Sender node ID of the heartbeat |
| hbState | input | 8 | State byte carried by the heartbeat |
| msTick | input | 1 | One-cycle pulse per millisecond |
| timeoutPulse | output | 4 | Per-slot lapse event |
| anyTimeout | output | 1 | Lapse event of any slot |
| monitorActive | output | 4 | Slot has been armed by a heartbeat |
| lapsed | output | 4 | Slot is in the lapsed state |
| entryState | output | 32 | Last accepted state byte per slot |

## Verification
A directed pass loads the 2000 ms word for node 1 and first leaves it silent for longer than the gap, which shows that an unarmed slot is never reported. It then arms the slot and steps to exactly the 1999th and 2000th tick, which pins down the lapse cycle. Further directed cases use zero node and zero gap fields, a heartbeat and a tick in the same cycle, and a write colliding with a heartbeat; these separate the priority rules from the plain counting path. A seeded random phase follows. It mixes frequent heartbeats from a small pool of node IDs, including duplicate slots for one node, with random ticks, short gaps and occasional rewrites. A reference model compares every output in every cycle, so that re-arming after a lapse and the independence of the slots are exercised many times.

// File: rtl/hbmon_pkg.sv
package hbmon_pkg;
  localparam int NODE_W  = 7;
  localparam int GAP_W   = 16;
  localparam int STATE_W = 8;
  localparam int WORD_W  = 32;
  localparam int NODE_LSB = 16;

  // Per-slot strobes from control to datapath
  typedef struct packed {
    logic reload;   // restart gap counter, capture state byte
    logic count;    // consume one millisecond tick
  } hbStrobe_t;
endpackage

// File: rtl/hbmon_datapath.sv
module hbmon_datapath
  import hbmon_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [WORD_W-1:0] cfgWdata,
  input  logic [STATE_W-1:0] hbState,
  input  hbStrobe_t [NUM_ENTRIES-1:0] strobes,
  output logic [NODE_W-1:0] slotNode [NUM_ENTRIES],
  output logic [NUM_ENTRIES-1:0] slotEnabled,
  output logic [NUM_ENTRIES-1:0] cntAtOne,
  output logic [NUM_ENTRIES*STATE_W-1:0] entryState
);
  logic [NODE_W-1:0] wrNode;
  logic [GAP_W-1:0] wrGap;
  logic wrUsable;

  assign wrNode = cfgWdata[NODE_LSB +: NODE_W];
  assign wrGap  = cfgWdata[GAP_W-1:0];
  // an all-zero word, a zero node or a zero gap leaves the slot disabled
  assign wrUsable = (cfgWdata != '0) && (wrNode != '0) && (wrGap != '0);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    logic [NODE_W-1:0] nodeQ;
    logic [GAP_W-1:0] gapQ;
    logic [GAP_W-1:0] remainQ;
    logic [STATE_W-1:0] stateQ;
    logic enQ;
    logic wrHit;

    assign wrHit = cfgWe && (cfgAddr == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        nodeQ   <= '0;
        gapQ    <= '0;
        enQ     <= 1'b0;
        remainQ <= '0;
        stateQ  <= '0;
      end else begin
        if (wrHit) begin
          nodeQ <= wrNode;
          gapQ  <= wrGap;
          enQ   <= wrUsable;
        end
        if (strobes[i].reload) begin
          remainQ <= gapQ;
          stateQ  <= hbState;
        end else if (strobes[i].count) begin
          remainQ <= remainQ - 1'b1;
        end
      end
    end

    assign slotNode[i]    = nodeQ;
    assign slotEnabled[i] = enQ;
    assign cntAtOne[i]    = (remainQ == GAP_W'(1));
    assign entryState[i*STATE_W +: STATE_W] = stateQ;
  end
endmodule

// File: rtl/hbmon_ctrl.sv
module hbmon_ctrl
  import hbmon_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic hbValid,
  input  logic [NODE_W-1:0] hbNodeId,
  input  logic msTick,
  input  logic [NODE_W-1:0] slotNode [NUM_ENTRIES],
  input  logic [NUM_ENTRIES-1:0] slotEnabled,
  input  logic [NUM_ENTRIES-1:0] cntAtOne,
  output hbStrobe_t [NUM_ENTRIES-1:0] strobes,
  output logic [NUM_ENTRIES-1:0] timeoutPulse,
  output logic [NUM_ENTRIES-1:0] monitorActive,
  output logic [NUM_ENTRIES-1:0] lapsed
);
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_slot
    logic wrHit, hbHit, expire;
    logic activeQ, lapsedQ, pulseQ;

    assign wrHit = cfgWe && (cfgAddr == ADDR_W'(i));
    assign hbHit = hbValid && slotEnabled[i] && (hbNodeId == slotNode[i]);

    // priority: write, then heartbeat, then tick
    assign strobes[i].reload = hbHit && !wrHit;
    assign strobes[i].count  = msTick && activeQ && !lapsedQ && !hbHit && !wrHit;
    assign expire = strobes[i].count && cntAtOne[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        activeQ <= 1'b0;
        lapsedQ <= 1'b0;
        pulseQ  <= 1'b0;
      end else if (wrHit) begin
        activeQ <= 1'b0;
        lapsedQ <= 1'b0;
        pulseQ  <= 1'b0;
      end else if (hbHit) begin
        activeQ <= 1'b1;
        lapsedQ <= 1'b0;
        pulseQ  <= 1'b0;
      end else if (expire) begin
        lapsedQ <= 1'b1;
        pulseQ  <= 1'b1;
      end else begin
        pulseQ  <= 1'b0;
      end
    end

    assign timeoutPulse[i]  = pulseQ;
    assign monitorActive[i] = activeQ;
    assign lapsed[i]        = lapsedQ;
  end
endmodule

// File: rtl/hbmon_top.sv
module hbmon_top
  import hbmon_pkg::*;
#(
  parameter int NUM_ENTRIES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgWe,
  input  logic [$clog2(NUM_ENTRIES)-1:0] cfgAddr,
  input  logic [31:0] cfgWdata,
  input  logic hbValid,
  input  logic [6:0] hbNodeId,
  input  logic [7:0] hbState,
  input  logic msTick,
  output logic [NUM_ENTRIES-1:0] timeoutPulse,
  output logic anyTimeout,
  output logic [NUM_ENTRIES-1:0] monitorActive,
  output logic [NUM_ENTRIES-1:0] lapsed,
  output logic [NUM_ENTRIES*8-1:0] entryState
);
  localparam int ADDR_W = $clog2(NUM_ENTRIES);

  hbStrobe_t [NUM_ENTRIES-1:0] strobes;
  logic [NODE_W-1:0] slotNode [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] slotEnabled;
  logic [NUM_ENTRIES-1:0] cntAtOne;

  hbmon_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .hbValid(hbValid), .hbNodeId(hbNodeId), .msTick(msTick),
    .slotNode(slotNode), .slotEnabled(slotEnabled), .cntAtOne(cntAtOne),
    .strobes(strobes), .timeoutPulse(timeoutPulse),
    .monitorActive(monitorActive), .lapsed(lapsed)
  );

  hbmon_datapath #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .hbState(hbState), .strobes(strobes),
    .slotNode(slotNode), .slotEnabled(slotEnabled), .cntAtOne(cntAtOne),
    .entryState(entryState)
  );

  assign anyTimeout = |timeoutPulse;
endmodule

// File: rtl/hbmon_checker.sv
module hbmon_checker #(
  parameter int NUM_ENTRIES = 4,
  parameter int ADDR_W = 2
) (
  input logic clk,
  input logic rstN,
  input logic cfgWe,
  input logic [ADDR_W-1:0] cfgAddr,
  input logic [NUM_ENTRIES-1:0] timeoutPulse,
  input logic [NUM_ENTRIES-1:0] monitorActive,
  input logic [NUM_ENTRIES-1:0] lapsed
);
  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_chk
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
      timeoutPulse[i] |=> !timeoutPulse[i]);
    a_r6_pulse_sets_lapsed: assert property (@(posedge clk) disable iff (!rstN)
      timeoutPulse[i] |-> lapsed[i]);
    a_r6_lapse_announced: assert property (@(posedge clk) disable iff (!rstN)
      $rose(lapsed[i]) |-> timeoutPulse[i]);
    a_r6_quiet_while_lapsed: assert property (@(posedge clk) disable iff (!rstN)
      (lapsed[i] && $past(lapsed[i])) |-> !timeoutPulse[i]);
    a_r3_lapse_needs_arming: assert property (@(posedge clk) disable iff (!rstN)
      lapsed[i] |-> monitorActive[i]);
    a_r8_write_disarms: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWe && cfgAddr == ADDR_W'(i)) |=> (!monitorActive[i] && !lapsed[i]));
  end
endmodule

bind hbmon_top hbmon_checker #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_hbmon_checker (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
  .timeoutPulse(timeoutPulse), .monitorActive(monitorActive), .lapsed(lapsed)
);

// File: tb/test_hbmon_top.sv
module test_hbmon_top;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic hbV = 1'b0;
  logic [6:0] hbNode = '0;
  logic [7:0] hbSt = '0;
  logic tick = 1'b0;

  logic [N-1:0] timeoutPulse, monitorActive, lapsed;
  logic anyTimeout;
  logic [N*8-1:0] entryState;

  int checks = 0;
  int fails = 0;

  // reference model state
  logic [31:0] mWord [N];
  bit mActive [N];
  bit mLapsed [N];
  bit mPulse [N];
  int mElapsed [N];
  logic [7:0] mState [N];

  always #5 clk = ~clk;

  hbmon_top #(.NUM_ENTRIES(N)) i_hbmon_top (
    .clk(clk), .rstN(rstN), .cfgWe(we), .cfgAddr(addr), .cfgWdata(wdata),
    .hbValid(hbV), .hbNodeId(hbNode), .hbState(hbSt), .msTick(tick),
    .timeoutPulse(timeoutPulse), .anyTimeout(anyTimeout),
    .monitorActive(monitorActive), .lapsed(lapsed), .entryState(entryState)
  );

  function automatic int wordNode(logic [31:0] w);
    return int'(w[22:16]);
  endfunction

  function automatic int wordGap(logic [31:0] w);
    return int'(w[15:0]);
  endfunction

  function automatic bit wordOn(logic [31:0] w);
    return (wordNode(w) != 0) && (wordGap(w) != 0);
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0d expected %0d", tag, $time, got, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < N; i++) begin
      mWord[i] = '0; mActive[i] = 0; mLapsed[i] = 0; mPulse[i] = 0;
      mElapsed[i] = 0; mState[i] = '0;
    end
  endtask

  task automatic modelEdge();
    for (int i = 0; i < N; i++) begin
      bit match;
      match = hbV && wordOn(mWord[i]) && (int'(hbNode) == wordNode(mWord[i]));
      mPulse[i] = 0;
      if (we && int'(addr) == i) begin
        mWord[i] = wdata; mActive[i] = 0; mLapsed[i] = 0; mElapsed[i] = 0;
      end else if (match) begin
        mActive[i] = 1; mLapsed[i] = 0; mElapsed[i] = 0; mState[i] = hbSt;
      end else if (tick && mActive[i] && !mLapsed[i]) begin
        mElapsed[i]++;
        if (mElapsed[i] == wordGap(mWord[i])) begin
          mLapsed[i] = 1; mPulse[i] = 1;
        end
      end
    end
  endtask

  task automatic compareAll();
    bit anyExp;
    anyExp = 0;
    for (int i = 0; i < N; i++) begin
      chk("R5 pulse", int'(timeoutPulse[i]), int'(mPulse[i]));
      chk("R4 active", int'(monitorActive[i]), int'(mActive[i]));
      chk("R6 lapsed", int'(lapsed[i]), int'(mLapsed[i]));
      chk("R10 state", int'(entryState[i*8 +: 8]), int'(mState[i]));
      anyExp |= mPulse[i];
    end
    chk("R9 summary", int'(anyTimeout), int'(anyExp));
  endtask

  task automatic doCycle();
    @(posedge clk);
    modelEdge();
    #2;
    compareAll();
  endtask

  task automatic idle();
    we = 0; hbV = 0; tick = 0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    we = 1; addr = 2'(a); wdata = d;
    doCycle();
    idle();
  endtask

  task automatic beat(input int node, input logic [7:0] st, input bit withTick);
    hbV = 1; hbNode = 7'(node); hbSt = st; tick = withTick;
    doCycle();
    idle();
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1;
      doCycle();
    end
    idle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd2024);
    modelReset();
    repeat (5) @(posedge clk);
    #2;
    rstN = 1;
    // R11: reset state
    chk("R11 pulse", int'(timeoutPulse), 0);
    chk("R11 active", int'(monitorActive), 0);
    chk("R11 lapsed", int'(lapsed), 0);
    chk("R11 any", int'(anyTimeout), 0);
    chk("R11 state", int'(entryState), 0);

    // R1: node 1, gap 2000, upper bits set and ignored
    wr(0, 32'hFF81_07D0);
    // R3: silent producer is never reported
    ticks(3000);
    chk("R3 not armed", int'(monitorActive[0]), 0);
    chk("R3 no lapse", int'(lapsed[0]), 0);
    beat(1, 8'h05, 0);
    chk("R4 armed", int'(monitorActive[0]), 1);
    chk("R10 state", int'(entryState[7:0]), 8'h05);
    ticks(1999);
    chk("R5 early", int'(timeoutPulse[0]), 0);
    tick = 1; doCycle(); idle();
    chk("R1 gap 2000", int'(timeoutPulse[0]), 1);
    chk("R9 summary", int'(anyTimeout), 1);
    doCycle();
    chk("R5 one cycle", int'(timeoutPulse[0]), 0);
    ticks(2500);
    chk("R6 held", int'(lapsed[0]), 1);
    beat(1, 8'h7F, 0);
    chk("R6 rearm", int'(lapsed[0]), 0);

    // R2: zero gap and zero node disable slots
    wr(1, 32'h0003_0000);
    wr(2, 32'h0000_0005);
    beat(3, 8'h01, 0);
    beat(0, 8'h01, 0);
    ticks(20);
    chk("R2 zero gap", int'(monitorActive[1]), 0);
    chk("R2 zero node", int'(monitorActive[2]), 0);

    // R7: heartbeat beats a tick in the same cycle
    wr(3, 32'h0009_0003);
    beat(9, 8'h04, 0);
    ticks(2);
    beat(9, 8'h04, 1);
    ticks(2);
    chk("R7 restart", int'(lapsed[3]), 0);
    tick = 1; doCycle(); idle();
    chk("R7 lapse", int'(timeoutPulse[3]), 1);

    // R4: other nodes leave the slot alone
    wr(1, 32'h0010_0004);
    beat(17, 8'h02, 0);
    beat(15, 8'h02, 0);
    chk("R4 other node", int'(monitorActive[1]), 0);

    // R8: write wins over a matching heartbeat
    hbV = 1; hbNode = 7'd9; hbSt = 8'h33; we = 1; addr = 2'd3; wdata = 32'h0009_0003;
    doCycle(); idle();
    chk("R8 disarm", int'(monitorActive[3]), 0);
    chk("R8 lapsed", int'(lapsed[3]), 0);
    chk("R10 write keeps", int'(entryState[31:24]), 8'h04);

    // random phase
    for (int c = 0; c < 20000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3) begin
        logic [31:0] w;
        w = $urandom;
        w[22:16] = ($urandom_range(0, 9) == 0) ? 7'd0 : 7'($urandom_range(1, 5));
        w[15:0] = ($urandom_range(0, 9) == 0) ? 16'd0 : 16'($urandom_range(1, 12));
        we = 1; addr = 2'($urandom_range(0, 3)); wdata = w;
      end
      hbV = ($urandom_range(0, 5) == 0);
      hbNode = 7'($urandom_range(0, 6));
      hbSt = 8'($urandom);
      tick = ($urandom_range(0, 1) == 1);
      doCycle();
      idle();
    end

    summary();
    $finish;
  end
endmodule